// File: doc/BRIEF.md
# UART Automatic Flow Control Engine

This block regulates the data flow of one UART channel in both directions. It sits between the channel's receive FIFO, its transmit FIFO and the serializer. It does not store data itself. It watches the receive FIFO fill level and the received-character strobe. From these it drives the active-low request-to-send line, gates the start of new transmit frames, and asks the serializer to insert an Xon or Xoff control character.

There are two forms of flow control, each selected separately:

- **Hardware flow control.** The request-to-send line follows two programmable fill thresholds with hysteresis. The clear-to-send input stops new frames.
- **Software flow control.** Programmable Xon and Xoff characters are recognised on receive. They are removed from the receive stream, and they stop or resume the local transmitter. The same characters are sent to the far end when the receive FIFO crosses the thresholds.

An optional mode lets any received character release a stopped transmitter.

The serializer finishes any frame it has already started. `txDataEn` only permits or forbids the start of the next data frame.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, `rtsN` is 0, `ctrlReq` is 0, and `txDataEn` is 1 when clear-to-send permits.
- R2: With `cfgAutoRts` set, `rtsN` goes to 1 on the clock edge after `rxLevel >= cfgHaltLvl`.
- R3: Once `rtsN` is 1, it stays 1 while `rxLevel > cfgResumeLvl`. It returns to 0 on the edge after `rxLevel <= cfgResumeLvl`, provided the halt threshold is not also met.
- R4: With `cfgAutoRts` clear, `rtsN` is 0 from the next edge on, whatever the fill level.
- R5: With `cfgAutoCts` set, `ctsN` = 1 forces `txDataEn` to 0 in the same cycle. With `cfgAutoCts` clear, `ctsN` has no effect on `txDataEn`.
- R6: With `cfgSwTx` set, receiving the character equal to `cfgXoffChar` drives `txDataEn` to 0 from the next edge. Receiving `cfgXonChar` drives it back to 1 from the next edge.
- R7: While stopped by Xoff, a received character other than Xon leaves the transmitter stopped when `cfgXonAny` is 0, and resumes it when `cfgXonAny` is 1. An Xoff character always stops the transmitter, even with `cfgXonAny` set.
- R8: `rxWrite` equals `rxStrobe`, except when `cfgSwTx` is set and `rxData` equals the Xon or Xoff character. In that case `rxWrite` is 0 in the same cycle.
- R9: With `cfgSwRx` set and no Xoff yet sent, `rxLevel >= cfgHaltLvl` raises `ctrlReq` on the next edge, with `ctrlChar = cfgXoffChar`. The request is held unchanged until a cycle with `ctrlAck` high.
- R10: After an acknowledged Xoff, `rxLevel <= cfgResumeLvl` raises `ctrlReq` on the next edge with `ctrlChar = cfgXonChar`. No new Xoff is requested while the far end is already stopped.
- R11: While `ctrlReq` is 1, `txDataEn` is 0, so a control character goes ahead of the next data byte. A transmitter stopped by a received Xoff still raises `ctrlReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxLevel | input | 7 | Receive FIFO fill level, 0 to 64 |
| rxStrobe | input | 1 | A received character is valid this cycle |
| rxData | input | 8 | Received character |
| ctsN | input | 1 | Clear-to-send, active low |
| ctrlAck | input | 1 | The serializer has taken the pending control character |
| cfgAutoRts | input | 1 | Enable threshold-driven request-to-send |
| cfgAutoCts | input | 1 | Enable clear-to-send gating of the transmitter |
| cfgSwTx | input | 1 | Obey received Xon/Xoff characters |
| cfgSwRx | input | 1 | Send Xon/Xoff from the receive fill level |
| cfgXonAny | input | 1 | Any received character resumes a stopped transmitter |
| cfgHaltLvl | input | 7 | Fill level that stops the far end |
| cfgResumeLvl | input | 7 | Fill level at or below which the far end resumes |
| cfgXonChar | input | 8 | Xon character |
| cfgXoffChar | input | 8 | Xoff character |
| rtsN | output | 1 | Request-to-send, active low |
| txDataEn | output | 1 | A new data frame may start |
| ctrlReq | output | 1 | Request to send a control character |
| ctrlChar | output | 8 | Control character to send |
| rxWrite | output | 1 | Write the received character into the receive FIFO |

## Verification
Some results depend only on inputs and are due in the same cycle as their stimulus:

- `rxWrite`
- the clear-to-send gating of `txDataEn`

The bench drives inputs on the falling edge and samples these one time unit later.

The other results come from state and are due on the first rising edge after the stimulus:

- `rtsN`
- the Xoff/Xon stop of the transmitter
- `ctrlReq` and `ctrlChar`

The bench samples these one time unit after that edge. The fill-level sweep runs up and down through every level from 0 to 64. The character sweep covers all 256 codes, so each threshold boundary and both matching characters fall exactly on a sampled cycle.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef struct packed {
    logic atHalt;
    logic atResume;
    logic isXon;
    logic isXoff;
  } fcFlags_t;

  typedef struct packed {
    logic rtsHold;
    logic haltTx;
    logic sendReq;
    logic sendXoff;
    logic dropChar;
  } fcCmd_t;

endpackage

// File: rtl/fc_datapath.sv
module fc_datapath
  import fc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CHAR_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  cfgHaltLvl,
  input  logic [LVL_W-1:0]  cfgResumeLvl,
  input  logic              rxStrobe,
  input  logic [CHAR_W-1:0] rxData,
  input  logic [CHAR_W-1:0] cfgXonChar,
  input  logic [CHAR_W-1:0] cfgXoffChar,
  input  logic              ctsN,
  input  logic              cfgAutoCts,
  input  logic              cfgAutoRts,
  input  fcCmd_t            cmd,
  output fcFlags_t          flags,
  output logic              rtsN,
  output logic              txDataEn,
  output logic              ctrlReq,
  output logic [CHAR_W-1:0] ctrlChar,
  output logic              rxWrite
);

  logic ctsOk;

  // Threshold compares and character matches feed the control module.
  always_comb begin
    flags.atHalt   = (rxLevel >= cfgHaltLvl);
    flags.atResume = (rxLevel <= cfgResumeLvl);
    flags.isXon    = (rxData == cfgXonChar);
    flags.isXoff   = (rxData == cfgXoffChar);
  end

  assign ctsOk    = !cfgAutoCts || !ctsN;
  assign rtsN     = cmd.rtsHold && cfgAutoRts;
  assign ctrlReq  = cmd.sendReq;
  assign ctrlChar = cmd.sendXoff ? cfgXoffChar : cfgXonChar;
  assign txDataEn = ctsOk && !cmd.haltTx && !cmd.sendReq;
  assign rxWrite  = rxStrobe && !cmd.dropChar;

endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  fcFlags_t flags,
  input  logic     rxStrobe,
  input  logic     ctrlAck,
  input  logic     cfgAutoRts,
  input  logic     cfgSwTx,
  input  logic     cfgSwRx,
  input  logic     cfgXonAny,
  output fcCmd_t   cmd
);

  logic rtsHold, haltTx, pending, pendXoff, remoteStopped;

  // Request-to-send hysteresis: set at the halt level, kept until the resume level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtsHold <= 1'b0;
    else       rtsHold <= cfgAutoRts && (flags.atHalt || (rtsHold && !flags.atResume));
  end

  // Local transmitter stop from received Xon/Xoff; an Xoff takes precedence.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                haltTx <= 1'b0;
    else if (!cfgSwTx)        haltTx <= 1'b0;
    else if (rxStrobe) begin
      if (flags.isXoff)                     haltTx <= 1'b1;
      else if (flags.isXon || cfgXonAny)    haltTx <= 1'b0;
    end
  end

  // Outgoing control-character request, held until acknowledged.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending       <= 1'b0;
      pendXoff      <= 1'b0;
      remoteStopped <= 1'b0;
    end else if (pending) begin
      if (ctrlAck) begin
        pending       <= 1'b0;
        remoteStopped <= pendXoff;
      end
    end else if (!cfgSwRx) begin
      remoteStopped <= 1'b0;
    end else if (!remoteStopped && flags.atHalt) begin
      pending  <= 1'b1;
      pendXoff <= 1'b1;
    end else if (remoteStopped && flags.atResume) begin
      pending  <= 1'b1;
      pendXoff <= 1'b0;
    end
  end

  always_comb begin
    cmd.rtsHold  = rtsHold;
    cmd.haltTx   = haltTx;
    cmd.sendReq  = pending;
    cmd.sendXoff = pendXoff;
    cmd.dropChar = cfgSwTx && (flags.isXon || flags.isXoff);
  end

  AST_RTS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAutoRts && flags.atHalt) |=> rtsHold); // R2
  AST_RTS_HYST: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAutoRts && rtsHold && !flags.atResume) |=> rtsHold); // R3
  AST_RTS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfgAutoRts |=> !rtsHold); // R4
  AST_XOFF_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSwTx && rxStrobe && flags.isXoff) |=> haltTx); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !ctrlAck) |=> (pending && $stable(pendXoff))); // R9

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import fc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CHAR_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              rxStrobe,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              ctsN,
  input  logic              ctrlAck,
  input  logic              cfgAutoRts,
  input  logic              cfgAutoCts,
  input  logic              cfgSwTx,
  input  logic              cfgSwRx,
  input  logic              cfgXonAny,
  input  logic [LVL_W-1:0]  cfgHaltLvl,
  input  logic [LVL_W-1:0]  cfgResumeLvl,
  input  logic [CHAR_W-1:0] cfgXonChar,
  input  logic [CHAR_W-1:0] cfgXoffChar,
  output logic              rtsN,
  output logic              txDataEn,
  output logic              ctrlReq,
  output logic [CHAR_W-1:0] ctrlChar,
  output logic              rxWrite
);

  fcFlags_t flags;
  fcCmd_t   cmd;

  fc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .flags(flags), .rxStrobe(rxStrobe),
    .ctrlAck(ctrlAck), .cfgAutoRts(cfgAutoRts), .cfgSwTx(cfgSwTx),
    .cfgSwRx(cfgSwRx), .cfgXonAny(cfgXonAny), .cmd(cmd)
  );

  fc_datapath #(.DEPTH(DEPTH), .CHAR_W(CHAR_W)) u_dp (
    .rxLevel(rxLevel), .cfgHaltLvl(cfgHaltLvl), .cfgResumeLvl(cfgResumeLvl),
    .rxStrobe(rxStrobe), .rxData(rxData), .cfgXonChar(cfgXonChar),
    .cfgXoffChar(cfgXoffChar), .ctsN(ctsN), .cfgAutoCts(cfgAutoCts),
    .cfgAutoRts(cfgAutoRts), .cmd(cmd), .flags(flags), .rtsN(rtsN),
    .txDataEn(txDataEn), .ctrlReq(ctrlReq), .ctrlChar(ctrlChar),
    .rxWrite(rxWrite)
  );

  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAutoCts && ctsN) |-> !txDataEn); // R5
  AST_CTRL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReq |-> !txDataEn); // R11
  AST_CONSUME: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSwTx && (rxData == cfgXonChar || rxData == cfgXoffChar)) |-> !rxWrite); // R8

endmodule

// File: tb/uart_flow_ctrl_bench.sv
module uart_flow_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  logic clk = 1'b0, rstN = 1'b0;
  logic [6:0] rxLevel = '0, cfgHaltLvl = 7'd40, cfgResumeLvl = 7'd10;
  logic rxStrobe = 0, ctsN = 0, ctrlAck = 0;
  logic cfgAutoRts = 0, cfgAutoCts = 0, cfgSwTx = 0, cfgSwRx = 0, cfgXonAny = 0;
  logic [7:0] rxData = '0;
  logic rtsN, txDataEn, ctrlReq, rxWrite;
  logic [7:0] ctrlChar;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flow_ctrl u_uart_flow_ctrl (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .rxStrobe(rxStrobe), .rxData(rxData),
    .ctsN(ctsN), .ctrlAck(ctrlAck), .cfgAutoRts(cfgAutoRts), .cfgAutoCts(cfgAutoCts),
    .cfgSwTx(cfgSwTx), .cfgSwRx(cfgSwRx), .cfgXonAny(cfgXonAny),
    .cfgHaltLvl(cfgHaltLvl), .cfgResumeLvl(cfgResumeLvl), .cfgXonChar(XON),
    .cfgXoffChar(XOFF), .rtsN(rtsN), .txDataEn(txDataEn), .ctrlReq(ctrlReq),
    .ctrlChar(ctrlChar), .rxWrite(rxWrite)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inputs change on the falling edge; combinational results are sampled 1 unit later.
  task automatic fall(); @(negedge clk); endtask
  // Registered results are sampled 1 unit after the next rising edge.
  task automatic rise(); @(posedge clk); #1; endtask

  task automatic sendChar(input logic [7:0] c);
    fall(); rxData = c; rxStrobe = 1; #1;
  endtask
  task automatic endChar();
    rise(); fall(); rxStrobe = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit expHold;
    repeat (2) @(posedge clk);
    fall(); rstN = 1; #1;
    // R1 reset state
    chk("R1 rtsN", rtsN, 0);
    chk("R1 ctrlReq", ctrlReq, 0);
    chk("R1 txDataEn", txDataEn, 1);

    // R2/R3 sweep up then down through every level
    cfgAutoRts = 1; expHold = 0;
    for (int lv = 0; lv <= 64; lv++) begin
      fall(); rxLevel = 7'(lv); rise();
      expHold = (lv >= 40) || (expHold && lv > 10);
      chk("R2 rtsN up", rtsN, int'(expHold));
    end
    for (int lv = 64; lv >= 0; lv--) begin
      fall(); rxLevel = 7'(lv); rise();
      expHold = (lv >= 40) || (expHold && lv > 10);
      chk("R3 rtsN down", rtsN, int'(expHold));
    end
    // R4 auto-RTS off ignores level
    fall(); rxLevel = 7'd64; rise(); chk("R4 precondition", rtsN, 1);
    fall(); cfgAutoRts = 0; rise(); chk("R4 rtsN off", rtsN, 0);
    fall(); rxLevel = 7'd0;

    // R5 clear-to-send gating
    fall(); cfgAutoCts = 1; ctsN = 1; #1; chk("R5 cts high", txDataEn, 0);
    fall(); ctsN = 0; #1; chk("R5 cts low", txDataEn, 1);
    fall(); cfgAutoCts = 0; ctsN = 1; #1; chk("R5 cts ignored", txDataEn, 1);
    fall(); ctsN = 0;

    // R8 character sweep with software flow on
    cfgSwTx = 1; cfgXonAny = 0;
    for (int c = 0; c < 256; c++) begin
      sendChar(8'(c));
      chk("R8 rxWrite swTx", rxWrite, int'(!(c == XON || c == XOFF)));
      endChar();
    end
    sendChar(XON); endChar();
    cfgSwTx = 0;
    sendChar(XOFF); chk("R8 rxWrite swTx off", rxWrite, 1); endChar();
    rise(); chk("R6 off ignores Xoff", txDataEn, 1);

    // R6 stop and resume
    cfgSwTx = 1;
    sendChar(XOFF); rise(); chk("R6 Xoff stops", txDataEn, 0); fall(); rxStrobe = 0;
    // R7 other char without any-resume
    sendChar(8'h41); chk("R7 char written", rxWrite, 1); endChar();
    #1; chk("R7 no resume", txDataEn, 0);
    sendChar(XON); rise(); chk("R6 Xon resumes", txDataEn, 1); fall(); rxStrobe = 0;
    // R7 any-resume
    cfgXonAny = 1;
    sendChar(XOFF); rise(); chk("R7 Xoff wins with any", txDataEn, 0); fall(); rxStrobe = 0;
    sendChar(8'h41); rise(); chk("R7 any resumes", txDataEn, 1); fall(); rxStrobe = 0;
    cfgXonAny = 0;

    // R9/R10/R11 outgoing control characters, transmitter also stopped by Xoff
    sendChar(XOFF); endChar();
    cfgSwRx = 1; rxLevel = 7'd40; rise();
    chk("R9 ctrlReq", ctrlReq, 1);
    chk("R9 ctrlChar", ctrlChar, XOFF);
    chk("R11 data blocked", txDataEn, 0);
    repeat (3) rise();
    chk("R9 held", ctrlReq, 1);
    chk("R9 held char", ctrlChar, XOFF);
    fall(); ctrlAck = 1; rise(); fall(); ctrlAck = 0; #1;
    chk("R9 cleared by ack", ctrlReq, 0);
    rise(); chk("R10 no repeat Xoff", ctrlReq, 0);
    fall(); rxLevel = 7'd11; rise(); chk("R10 above resume", ctrlReq, 0);
    fall(); rxLevel = 7'd10; rise();
    chk("R10 Xon req", ctrlReq, 1);
    chk("R10 Xon char", ctrlChar, XON);
    fall(); ctrlAck = 1; rise(); fall(); ctrlAck = 0; #1;
    chk("R10 cleared", ctrlReq, 0);
    sendChar(XON); endChar(); #1;
    chk("R11 data resumes", txDataEn, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule